// File: doc/BRIEF.md
# Byte Selection Sort Engine

This block sorts a list of unsigned bytes into ascending order where the list already sits, in a single-port byte-addressed memory. A one-cycle `start` pulse supplies a base address and a length. The engine then works through the list with straight selection, one memory access at a time, over a request/ready interface. It signals completion with a single-cycle `done` pulse.

The outer index `j` starts at the last position and counts down toward 1. For each value of `j`, the element at `j` is first loaded into a running-maximum register. The inner index `k` then scans from `j-1` down to 0, both ends included. When the element at `k` is strictly larger than the running maximum, the two are exchanged immediately. The larger value is written to position `j` and the old maximum is written to position `k`. The value read from `k` becomes the new maximum. Every element address is the latched base plus an index.

The control state machine has seven states:

- **IDLE** waits for `start`. It goes to FINISH when the length is below 2, and to LOAD_MAX otherwise.
- **LOAD_MAX** reads position `j`. On `ready` it latches the maximum, sets `k = j-1` and goes to READ_K.
- **READ_K** reads position `k`. On `ready` it goes to WR_J if the element is greater than the maximum, and to STEP otherwise.
- **WR_J** writes the element to position `j`. On `ready` it goes to WR_K.
- **WR_K** writes the old maximum to position `k`. On `ready` it promotes the element to maximum and goes to STEP.
- **STEP** decrements `k` and returns to READ_K while `k` is not 0. When `k` is 0 and `j` is not 1, it decrements `j` and goes to LOAD_MAX. When `k` is 0 and `j` is 1, it goes to FINISH.
- **FINISH** raises `done` and returns to IDLE.

Top module: `bytesort_engine`

## Requirements
- R1: When `done` pulses, the bytes from base to base+N-1 are in non-decreasing unsigned order.
- R2: The sorted region holds exactly the multiset of bytes it held before `start`.
- R3: A length of 0 or 1 raises `done` in the cycle after `start` is sampled, and no memory request is made.
- R4: `done` is high for exactly one cycle per accepted `start`. It is low after reset.
- R5: A `start` that arrives while `busy` is high is ignored. The running sort keeps its own base and length, and the memory outside that list is not touched.
- R6: A request (`mem_req`=1) stays asserted with unchanged `mem_addr`, `mem_we` and `mem_wdata` until it is accepted by `mem_ready`=1.
- R7: Every memory access falls within base to base+N-1 of the accepted list.
- R8: An exchange happens only when the element at `k` is strictly greater than the maximum. It is two back-to-back writes: position `j` first, then position `k`. A list that is already ascending, or that has all elements equal, is sorted with no writes at all.
- R9: A sort of N≥2 elements makes exactly N(N-1)/2 + (N-1) reads.
- R10: `busy` is high from the cycle after an accepted `start` of N≥2 until `done`. It is low after reset. `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sort; sampled only when idle |
| base_addr | input | ADDR_W | Address of list element 0 |
| length | input | LEN_W | Number of elements N |
| busy | output | 1 | Sort in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Access accepted at this clock edge |

## Verification
A corrupted running maximum or index shows up only at the end of a sort, as an unsorted region or a value that was lost or duplicated. The bench therefore checks both the order and a byte histogram as soon as `done` arrives. A wrong loop bound, or a wrong transition out of READ_K or STEP, shows up within the run as a changed read or write count, or as an access outside the list. The bench counts these accesses as they complete. A dropped or reordered exchange write is caught by the bound checker one cycle after the first write is accepted. A request that wavers while `mem_ready` is low is caught at the next cycle.

// File: rtl/bytesort_pkg.sv
package bytesort_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_MAX,
        ST_READ_K,
        ST_WR_J,
        ST_WR_K,
        ST_STEP,
        ST_FINISH
    } sort_state_t;

endpackage

// File: rtl/bsort_index.sv
module bsort_index #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_j,
    input  logic [IW-1:0] len_in,
    input  logic          dec_j,
    input  logic          load_k,
    input  logic          dec_k,
    output logic [IW-1:0] j_idx,
    output logic [IW-1:0] k_idx,
    output logic          k_zero,
    output logic          j_one
);

    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] j_q;
    logic [IW-1:0] k_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_q <= '0;
        end else if (load_j) begin
            j_q <= len_in - ONE;
        end else if (dec_j) begin
            j_q <= j_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q <= '0;
        end else if (load_k) begin
            k_q <= j_q - ONE;
        end else if (dec_k) begin
            k_q <= k_q - ONE;
        end
    end

    assign j_idx  = j_q;
    assign k_idx  = k_q;
    assign k_zero = (k_q == '0);
    assign j_one  = (j_q == ONE);

endmodule

// File: rtl/bsort_datapath.sv
module bsort_datapath #(
    parameter int AW = 16,
    parameter int IW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_base,
    input  logic [AW-1:0] base_in,
    input  logic          cap_max,
    input  logic          cap_elem,
    input  logic          promote,
    input  logic          use_j,
    input  logic [IW-1:0] j_idx,
    input  logic [IW-1:0] k_idx,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          elem_gt
);

    logic [AW-1:0] base_q;
    logic [DW-1:0] max_q;
    logic [DW-1:0] elem_q;
    logic [IW-1:0] sel_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (latch_base) begin
            base_q <= base_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
        end else if (cap_max) begin
            max_q <= rdata;
        end else if (promote) begin
            max_q <= elem_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_q <= '0;
        end else if (cap_elem) begin
            elem_q <= rdata;
        end
    end

    always_comb begin
        sel_idx = use_j ? j_idx : k_idx;
        addr    = base_q + AW'(sel_idx);
        wdata   = use_j ? elem_q : max_q;
        elem_gt = (rdata > max_q);
    end

endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
    import bytesort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic len_short,
    input  logic mem_ready,
    input  logic elem_gt,
    input  logic k_zero,
    input  logic j_one,
    output logic busy,
    output logic done,
    output logic mem_req,
    output logic mem_we,
    output logic use_j,
    output logic accept,
    output logic cap_max,
    output logic load_k,
    output logic cap_elem,
    output logic promote,
    output logic dec_k,
    output logic dec_j
);

    sort_state_t state_q;
    sort_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = len_short ? ST_FINISH : ST_LOAD_MAX;
                end
            end
            ST_LOAD_MAX: begin
                if (mem_ready) begin
                    state_d = ST_READ_K;
                end
            end
            ST_READ_K: begin
                if (mem_ready) begin
                    state_d = elem_gt ? ST_WR_J : ST_STEP;
                end
            end
            ST_WR_J: begin
                if (mem_ready) begin
                    state_d = ST_WR_K;
                end
            end
            ST_WR_K: begin
                if (mem_ready) begin
                    state_d = ST_STEP;
                end
            end
            ST_STEP: begin
                if (!k_zero) begin
                    state_d = ST_READ_K;
                end else if (j_one) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_LOAD_MAX;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        use_j    = 1'b0;
        accept   = 1'b0;
        cap_max  = 1'b0;
        load_k   = 1'b0;
        cap_elem = 1'b0;
        promote  = 1'b0;
        dec_k    = 1'b0;
        dec_j    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start;
            end
            ST_LOAD_MAX: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                use_j   = 1'b1;
                cap_max = mem_ready;
                load_k  = mem_ready;
            end
            ST_READ_K: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                cap_elem = mem_ready;
            end
            ST_WR_J: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
                use_j   = 1'b1;
            end
            ST_WR_K: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
                promote = mem_ready;
            end
            ST_STEP: begin
                busy  = 1'b1;
                dec_k = !k_zero;
                dec_j = k_zero && !j_one;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bytesort_engine.sv
module bytesort_engine #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  length,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    localparam logic [LEN_W-1:0] MIN_SORT = LEN_W'(2);

    logic             len_short;
    logic             use_j;
    logic             accept;
    logic             cap_max;
    logic             load_k;
    logic             cap_elem;
    logic             promote;
    logic             dec_k;
    logic             dec_j;
    logic             elem_gt;
    logic             k_zero;
    logic             j_one;
    logic [LEN_W-1:0] j_idx;
    logic [LEN_W-1:0] k_idx;

    assign len_short = (length < MIN_SORT);

    bsort_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_short (len_short),
        .mem_ready (mem_ready),
        .elem_gt   (elem_gt),
        .k_zero    (k_zero),
        .j_one     (j_one),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .use_j     (use_j),
        .accept    (accept),
        .cap_max   (cap_max),
        .load_k    (load_k),
        .cap_elem  (cap_elem),
        .promote   (promote),
        .dec_k     (dec_k),
        .dec_j     (dec_j)
    );

    bsort_index #(.IW(LEN_W)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_j (accept),
        .len_in (length),
        .dec_j  (dec_j),
        .load_k (load_k),
        .dec_k  (dec_k),
        .j_idx  (j_idx),
        .k_idx  (k_idx),
        .k_zero (k_zero),
        .j_one  (j_one)
    );

    bsort_datapath #(.AW(ADDR_W), .IW(LEN_W), .DW(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_base (accept),
        .base_in    (base_addr),
        .cap_max    (cap_max),
        .cap_elem   (cap_elem),
        .promote    (promote),
        .use_j      (use_j),
        .j_idx      (j_idx),
        .k_idx      (k_idx),
        .rdata      (mem_rdata),
        .addr       (mem_addr),
        .wdata      (mem_wdata),
        .elem_gt    (elem_gt)
    );

endmodule

// File: rtl/bytesort_engine_chk.sv
module bytesort_engine_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          use_j
);

    // R4: completion is a single-cycle pulse
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a pending request holds still until accepted
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10: no memory traffic outside a running sort
    p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R8: the write to position j is followed at once by the write to position k
    p_swap_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && use_j) |=> (mem_req && mem_we && !use_j));

    // R5: busy rises only in response to a start pulse
    p_busy_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: done never coincides with an active sort
    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_req);

endmodule

bind bytesort_engine bytesort_engine_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .use_j     (use_j)
);

// File: tb/bytesort_engine_test.sv
module bytesort_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [15:0] length = '0;
    logic        busy;
    logic        done;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ready;

    logic [7:0]  mem  [0:255];
    logic [7:0]  orig [0:255];
    logic [1:0]  wcnt = '0;
    logic        slow = 1'b0;

    int checks = 0;
    int fails = 0;
    int n_reads = 0;
    int n_writes = 0;
    int n_oor = 0;
    int n_hold_bad = 0;
    int win_lo = 0;
    int win_hi = 255;
    int cyc = 0;

    logic        pend = 1'b0;
    logic [15:0] pend_addr = '0;
    logic        pend_we = 1'b0;
    logic [7:0]  pend_wdata = '0;

    always #5 clk = ~clk;

    bytesort_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .length    (length),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    assign mem_ready = mem_req && (wcnt == 2'd0);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            wcnt <= slow ? 2'($urandom_range(0, 3)) : 2'd0;
        end else if (mem_req && wcnt != 2'd0) begin
            wcnt <= wcnt - 2'd1;
        end
    end

    // access monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend && (!mem_req || mem_addr != pend_addr || mem_we != pend_we ||
                         (pend_we && mem_wdata != pend_wdata)))
                n_hold_bad++;
            if (mem_req && (int'(mem_addr) < win_lo || int'(mem_addr) > win_hi))
                n_oor++;
            if (mem_req && mem_ready) begin
                if (mem_we) n_writes++;
                else n_reads++;
            end
            pend       = mem_req && !mem_ready;
            pend_addr  = mem_addr;
            pend_we    = mem_we;
            pend_wdata = mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            summary_and_end();
        end
    end

    task automatic fill(input int b, input int n, input int kind);
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom_range(0, 255));
        for (int i = 0; i < n; i++) begin
            case (kind)
                1: mem[b+i] = 8'(i * 3);
                2: mem[b+i] = 8'(250 - i * 5);
                3: mem[b+i] = 8'h5A;
                default: mem[b+i] = 8'($urandom_range(0, 255));
            endcase
        end
        for (int i = 0; i < 256; i++) orig[i] = mem[i];
    endtask

    task automatic clear_counts(input int b, input int n);
        n_reads = 0;
        n_writes = 0;
        n_oor = 0;
        n_hold_bad = 0;
        win_lo = b;
        win_hi = b + n - 1;
    endtask

    task automatic pulse_start(input int b, input int n);
        base_addr = 16'(b);
        length    = 16'(n);
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 60000; t++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_result(input int b, input int n, input string tag);
        int hist [0:255];
        int bad_order = 0;
        int bad_perm = 0;
        int bad_out = 0;
        for (int i = 0; i < 256; i++) hist[i] = 0;
        for (int i = 0; i + 1 < n; i++)
            if (mem[b+i] > mem[b+i+1]) bad_order++;
        for (int i = 0; i < n; i++) begin
            hist[orig[b+i]]++;
            hist[mem[b+i]]--;
        end
        for (int i = 0; i < 256; i++) if (hist[i] != 0) bad_perm++;
        for (int i = 0; i < 256; i++)
            if ((i < b || i >= b + n) && mem[i] != orig[i]) bad_out++;
        chk(bad_order == 0, {"R1 order ", tag}, bad_order, 0);
        chk(bad_perm == 0, {"R2 permutation ", tag}, bad_perm, 0);
        chk(bad_out == 0, {"R5 outside untouched ", tag}, bad_out, 0);
        chk(n_oor == 0, {"R7 address window ", tag}, n_oor, 0);
        chk(n_hold_bad == 0, {"R6 request hold ", tag}, n_hold_bad, 0);
    endtask

    task automatic run_sort(input int b, input int n, input int kind, input bit slw,
                            input bit zero_writes, input string tag);
        bit seen;
        int exp_reads;
        slow = slw;
        fill(b, n, kind);
        clear_counts(b, n);
        pulse_start(b, n);
        chk(busy == 1'b1, {"R10 busy after start ", tag}, int'(busy), 1);
        wait_done(seen);
        chk(seen, {"R1 done seen ", tag}, int'(seen), 1);
        chk(busy == 1'b0, {"R10 busy low at done ", tag}, int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, {"R4 done one cycle ", tag}, int'(done), 0);
        check_result(b, n, tag);
        exp_reads = (n - 1) * n / 2 + (n - 1);
        chk(n_reads == exp_reads, {"R9 read count ", tag}, n_reads, exp_reads);
        if (zero_writes)
            chk(n_writes == 0, {"R8 no exchange ", tag}, n_writes, 0);
        else
            chk(n_writes % 2 == 0, {"R8 paired writes ", tag}, n_writes % 2, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R4 reset done", int'(done), 0);
        chk(mem_req == 1'b0, "R10 reset req", int'(mem_req), 0);
    endtask

    task automatic t_short(input int n);
        fill(40, 2, 0);
        clear_counts(40, 1);
        pulse_start(40, n);
        chk(done == 1'b1, "R3 immediate done", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R4 short done pulse", int'(done), 0);
        chk(n_reads + n_writes == 0, "R3 no access", n_reads + n_writes, 0);
        chk(mem[40] == orig[40] && mem[41] == orig[41], "R3 memory intact",
            int'(mem[40]), int'(orig[40]));
    endtask

    task automatic t_start_while_busy();
        bit seen;
        slow = 1'b1;
        fill(10, 20, 2);
        clear_counts(10, 20);
        pulse_start(10, 20);
        repeat (5) @(negedge clk);
        pulse_start(100, 30);
        chk(busy == 1'b1, "R5 still busy", int'(busy), 1);
        wait_done(seen);
        chk(seen, "R5 done seen", int'(seen), 1);
        @(negedge clk);
        check_result(10, 20, "busy-start");
        chk(n_reads == 19 * 20 / 2 + 19, "R5 R9 original length kept", n_reads, 209);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R5 no second sort", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short(0);
        t_short(1);
        run_sort(0, 2, 2, 1'b0, 1'b0, "n2 swap");
        run_sort(20, 16, 0, 1'b1, 1'b0, "random16");
        run_sort(60, 8, 1, 1'b0, 1'b1, "ascending");
        run_sort(80, 10, 2, 1'b1, 1'b0, "descending");
        run_sort(120, 6, 3, 1'b1, 1'b1, "equal");
        run_sort(200, 40, 0, 1'b1, 1'b0, "random40");
        run_sort(5, 33, 0, 1'b0, 1'b0, "random33");
        t_start_while_busy();
        summary_and_end();
    end

endmodule